// File: doc/BRIEF.md
# Memory Ordering Readiness Tracker

This block keeps the set of in-flight memory operations in an out-of-order core and decides, from age alone, whether a given operation may issue. Every operation carries a sequence index that grows with program order. Lower values are older. Indices are compared as unsigned numbers and never wrap. The index must stay within range for the whole run.

A dispatch port records an operation with load, store and side-effect flags. A load takes a slot in the load table and a store takes a slot in the store table. An operation that is both takes a slot in each. The side-effect flag also marks the operation as a barrier in the table or tables it enters. The availability code tells the front end whether a dispatch would stall, and the full and empty flags show table occupancy.

A query port takes an index with its flags. In the same cycle it returns a ready flag and the index of the operation the query must wait on. A completion port removes finished operations. No addresses are compared. A no-alias mode lets loads skip the store-ordering rule.

Top module: `mem_order_tracker`

## Requirements
- R1: A dispatch with the load flag takes a load-table slot, and one with the store flag takes a store-table slot. A single operation may take both. The empty and full outputs reflect occupancy from the cycle after the dispatch edge.
- R2: A dispatch that also has the side-effect flag becomes a barrier in each table it enters.
- R3: `avail_o` depends only on the load and store flags at the dispatch port and on table fullness:
  - 1 means a load is offered and the load table is full.
  - Otherwise, 2 means a store is offered and the store table is full.
  - Otherwise the code is 0.
  - The load case wins when both apply.
- R4: A queried load younger than the oldest load barrier is not ready and reports that barrier's index. A load barrier that is not the oldest load is not ready and reports the oldest load's index.
- R5: A queried store younger than the oldest store barrier is not ready and reports that barrier's index. A store barrier that is not the oldest store is not ready and reports the oldest store's index.
- R6: With `cfg_no_alias_i` high, a load that clears the barrier rules is ready.
- R7: With `cfg_no_alias_i` low, or for a store, an operation younger than the oldest pending store is not ready and reports that store's index.
- R8: An operation not blocked by R4 to R7 is ready in any of these cases: the load table is empty, its index is not above the oldest load, or it is a load. Otherwise, a store younger than the oldest load is blocked by that load and reports its index.
- R9: Whenever the query result is ready, the reported wait index equals the queried index.
- R10: Completion removes the index from the tables selected by its flags. The barrier mark is cleared only if the index is the oldest barrier of that table. A non-oldest barrier stays in force, and keeps its slot, until it is completed again as the oldest barrier.
- R11: A dispatch whose index is already held in a target table, or whose target table is full, sets `err_o`. The flag stays set until reset, and neither table is changed by that dispatch.
- R12: After reset both tables are empty and not full, and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_no_alias_i | input | 1 | Loads ignore pending stores when high |
| disp_valid_i | input | 1 | Dispatch request |
| disp_idx_i | input | IDX_W | Sequence index of dispatched operation |
| disp_load_i | input | 1 | Operation reads memory |
| disp_store_i | input | 1 | Operation writes memory |
| disp_side_i | input | 1 | Operation has side effects (barrier) |
| avail_o | output | 2 | 0 available, 1 load table full, 2 store table full |
| cmpl_valid_i | input | 1 | Completion request |
| cmpl_idx_i | input | IDX_W | Sequence index of completed operation |
| cmpl_load_i | input | 1 | Remove from load table |
| cmpl_store_i | input | 1 | Remove from store table |
| qry_idx_i | input | IDX_W | Index being queried |
| qry_load_i | input | 1 | Queried operation is a load |
| qry_store_i | input | 1 | Queried operation is a store |
| qry_ready_o | output | 1 | Queried operation may issue |
| qry_wait_idx_o | output | IDX_W | Blocking index, or the queried index when ready |
| lq_full_o | output | 1 | Load table has no free slot |
| sq_full_o | output | 1 | Store table has no free slot |
| lq_empty_o | output | 1 | No load pending |
| sq_empty_o | output | 1 | No store pending |
| err_o | output | 1 | Sticky illegal-dispatch flag |

## Verification
The queries use four kinds of mixes:
- Interleaved loads and stores. These separate the store-ordering block (R7) from the load-before-store block (R8), and the same queries are repeated in no-alias mode.
- Chains of loads and of stores around one barrier. Each of these queries hits exactly one of the two barrier rules.
- One operation that is load, store and barrier at once. This shows the barrier mark landing in both tables.
- A barrier completed out of age order. This tells the oldest-only barrier removal apart from plain queue removal.

Fill, duplicate and overflow patterns separate load-first availability priority from store fullness. They also show that rejected dispatches leave the tables untouched.

// File: rtl/mo_pkg.sv
package mo_pkg;
  typedef enum logic [1:0] {
    AV_OK      = 2'd0,
    AV_LQ_FULL = 2'd1,
    AV_SQ_FULL = 2'd2
  } avail_e;
endpackage

// File: rtl/mo_min_search.sv
module mo_min_search #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 8
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][IDX_W-1:0] idx_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        min_o
);
  always_comb begin
    any_o = 1'b0;
    min_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_i[i] && (!any_o || idx_i[i] < min_o)) begin
        any_o = 1'b1;
        min_o = idx_i[i];
      end
    end
  end
endmodule

// File: rtl/mo_age_table.sv
module mo_age_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             alloc_bar_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic             cmpl_i,
  input  logic [IDX_W-1:0] cmpl_idx_i,
  output logic             q_any_o,
  output logic [IDX_W-1:0] q_min_o,
  output logic             b_any_o,
  output logic [IDX_W-1:0] b_min_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             hit_o
);
  logic [DEPTH-1:0]            vld_q, bar_q, free, sel, alloc_match, cmpl_match;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;

  // a slot stays held while it is in the queue or the barrier set
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign free[g]        = ~(vld_q[g] | bar_q[g]);
    assign alloc_match[g] = vld_q[g] && (idx_q[g] == alloc_idx_i);
    assign cmpl_match[g]  = vld_q[g] && (idx_q[g] == cmpl_idx_i);
  end

  assign full_o  = ~|free;
  assign empty_o = ~|vld_q;
  assign hit_o   = |alloc_match;

  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free[i]) sel = DEPTH'(1) << i;
    end
  end

  mo_min_search #(.N(DEPTH), .IDX_W(IDX_W)) u_q_min (
    .vld_i(vld_q), .idx_i(idx_q), .any_o(q_any_o), .min_o(q_min_o));

  mo_min_search #(.N(DEPTH), .IDX_W(IDX_W)) u_b_min (
    .vld_i(bar_q), .idx_i(idx_q), .any_o(b_any_o), .min_o(b_min_o));

  logic bar_retire;
  assign bar_retire = cmpl_i && b_any_o && (cmpl_idx_i == b_min_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      bar_q <= '0;
      idx_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmpl_i && cmpl_match[i]) vld_q[i] <= 1'b0;
        if (bar_retire && bar_q[i] && idx_q[i] == b_min_o) bar_q[i] <= 1'b0;
        if (alloc_i && sel[i]) begin
          vld_q[i] <= 1'b1;
          bar_q[i] <= alloc_bar_i;
          idx_q[i] <= alloc_idx_i;
        end
      end
    end
  end

  assert_alloc_room_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (!full_o && !hit_o));

  assert_last_retire_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && |cmpl_match && $countones(vld_q) == 1 && !alloc_i) |=> empty_o);

  assert_barrier_kept_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_any_o && !(cmpl_i && cmpl_idx_i == b_min_o)) |=> b_any_o);
endmodule

// File: rtl/mo_ready_logic.sv
module mo_ready_logic #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             no_alias_i,
  input  logic [IDX_W-1:0] q_idx_i,
  input  logic             q_load_i,
  input  logic             q_store_i,
  input  logic             lq_any_i,
  input  logic [IDX_W-1:0] lq_min_i,
  input  logic             lb_any_i,
  input  logic [IDX_W-1:0] lb_min_i,
  input  logic             sq_any_i,
  input  logic [IDX_W-1:0] sq_min_i,
  input  logic             sb_any_i,
  input  logic [IDX_W-1:0] sb_min_i,
  output logic             ready_o,
  output logic [IDX_W-1:0] wait_o
);
  logic done;

  always_comb begin
    ready_o = 1'b1;
    wait_o  = q_idx_i;
    done    = 1'b0;
    if (q_load_i && lb_any_i) begin
      if (q_idx_i > lb_min_i) begin
        ready_o = 1'b0; wait_o = lb_min_i; done = 1'b1;
      end else if (q_idx_i == lb_min_i && lq_any_i && q_idx_i != lq_min_i) begin
        ready_o = 1'b0; wait_o = lq_min_i; done = 1'b1;
      end
    end
    if (!done && q_store_i && sb_any_i) begin
      if (q_idx_i > sb_min_i) begin
        ready_o = 1'b0; wait_o = sb_min_i; done = 1'b1;
      end else if (q_idx_i == sb_min_i && sq_any_i && q_idx_i != sq_min_i) begin
        ready_o = 1'b0; wait_o = sq_min_i; done = 1'b1;
      end
    end
    if (!done && !(no_alias_i && q_load_i)) begin
      if (sq_any_i && q_idx_i > sq_min_i) begin
        ready_o = 1'b0; wait_o = sq_min_i;
      end else if (lq_any_i && q_idx_i > lq_min_i && !q_load_i) begin
        ready_o = 1'b0; wait_o = lq_min_i;
      end
    end
  end
endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker
  import mo_pkg::*;
#(
  parameter int unsigned LQ_DEPTH = 4,
  parameter int unsigned SQ_DEPTH = 4,
  parameter int unsigned IDX_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_no_alias_i,
  input  logic             disp_valid_i,
  input  logic [IDX_W-1:0] disp_idx_i,
  input  logic             disp_load_i,
  input  logic             disp_store_i,
  input  logic             disp_side_i,
  output logic [1:0]       avail_o,
  input  logic             cmpl_valid_i,
  input  logic [IDX_W-1:0] cmpl_idx_i,
  input  logic             cmpl_load_i,
  input  logic             cmpl_store_i,
  input  logic [IDX_W-1:0] qry_idx_i,
  input  logic             qry_load_i,
  input  logic             qry_store_i,
  output logic             qry_ready_o,
  output logic [IDX_W-1:0] qry_wait_idx_o,
  output logic             lq_full_o,
  output logic             sq_full_o,
  output logic             lq_empty_o,
  output logic             sq_empty_o,
  output logic             err_o
);
  logic             lq_any, lb_any, sq_any, sb_any, lq_hit, sq_hit;
  logic [IDX_W-1:0] lq_min, lb_min, sq_min, sb_min;
  logic             reject, accept, err_q;
  avail_e           avail;

  assign reject = disp_valid_i &&
                  ((disp_load_i  && (lq_full_o || lq_hit)) ||
                   (disp_store_i && (sq_full_o || sq_hit)));
  assign accept = disp_valid_i && !reject;

  mo_age_table #(.DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_ldq (
    .clk_i, .rst_ni,
    .alloc_i(accept && disp_load_i), .alloc_bar_i(disp_side_i), .alloc_idx_i(disp_idx_i),
    .cmpl_i(cmpl_valid_i && cmpl_load_i), .cmpl_idx_i,
    .q_any_o(lq_any), .q_min_o(lq_min), .b_any_o(lb_any), .b_min_o(lb_min),
    .full_o(lq_full_o), .empty_o(lq_empty_o), .hit_o(lq_hit));

  mo_age_table #(.DEPTH(SQ_DEPTH), .IDX_W(IDX_W)) u_stq (
    .clk_i, .rst_ni,
    .alloc_i(accept && disp_store_i), .alloc_bar_i(disp_side_i), .alloc_idx_i(disp_idx_i),
    .cmpl_i(cmpl_valid_i && cmpl_store_i), .cmpl_idx_i,
    .q_any_o(sq_any), .q_min_o(sq_min), .b_any_o(sb_any), .b_min_o(sb_min),
    .full_o(sq_full_o), .empty_o(sq_empty_o), .hit_o(sq_hit));

  mo_ready_logic #(.IDX_W(IDX_W)) u_rdy (
    .no_alias_i(cfg_no_alias_i), .q_idx_i(qry_idx_i), .q_load_i(qry_load_i),
    .q_store_i(qry_store_i),
    .lq_any_i(lq_any), .lq_min_i(lq_min), .lb_any_i(lb_any), .lb_min_i(lb_min),
    .sq_any_i(sq_any), .sq_min_i(sq_min), .sb_any_i(sb_any), .sb_min_i(sb_min),
    .ready_o(qry_ready_o), .wait_o(qry_wait_idx_o));

  always_comb begin
    if (disp_load_i && lq_full_o)       avail = AV_LQ_FULL;
    else if (disp_store_i && sq_full_o) avail = AV_SQ_FULL;
    else                                avail = AV_OK;
  end
  assign avail_o = avail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
  end
  assign err_o = err_q;

  assert_err_sticky_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_ready_self_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_ready_o |-> (qry_wait_idx_o == qry_idx_i));

  assert_lbar_block_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_load_i && lb_any && qry_idx_i > lb_min) |-> (!qry_ready_o && qry_wait_idx_o == lb_min));

  assert_sbar_block_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_store_i && !qry_load_i && sb_any && qry_idx_i > sb_min)
      |-> (!qry_ready_o && qry_wait_idx_o == sb_min));

  assert_noalias_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_no_alias_i && qry_load_i && !qry_store_i && !lb_any) |-> qry_ready_o);

  assert_avail_prio_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_load_i && lq_full_o) |-> (avail_o == 2'd1));
endmodule

// File: tb/tb_mem_order_tracker.sv
`timescale 1ns/1ps
module tb_mem_order_tracker;
  typedef struct {
    int         kind;   // 0 query, 1 avail, 2 status
    logic [7:0] a;
    logic [7:0] b;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic no_alias = 0, disp_v = 0, disp_ld = 0, disp_st = 0, disp_sd = 0;
  logic cmpl_v = 0, cmpl_ld = 0, cmpl_st = 0, q_ld = 0, q_st = 0;
  logic [7:0] disp_idx = 0, cmpl_idx = 0, q_idx = 0, q_wait;
  logic [1:0] avail;
  logic q_rdy, lqf, sqf, lqe, sqe, err;
  int vectors = 0, miscompares = 0;
  bit finished = 0;
  exp_t sb[$];
  exp_t cur;

  always #4 clk = ~clk;

  mem_order_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_no_alias_i(no_alias),
    .disp_valid_i(disp_v), .disp_idx_i(disp_idx), .disp_load_i(disp_ld),
    .disp_store_i(disp_st), .disp_side_i(disp_sd), .avail_o(avail),
    .cmpl_valid_i(cmpl_v), .cmpl_idx_i(cmpl_idx), .cmpl_load_i(cmpl_ld),
    .cmpl_store_i(cmpl_st), .qry_idx_i(q_idx), .qry_load_i(q_ld),
    .qry_store_i(q_st), .qry_ready_o(q_rdy), .qry_wait_idx_o(q_wait),
    .lq_full_o(lqf), .sq_full_o(sqf), .lq_empty_o(lqe), .sq_empty_o(sqe),
    .err_o(err));

  // monitor: compares every pending expectation away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      logic [7:0] ga, gb;
      cur = sb.pop_front();
      vectors++;
      case (cur.kind)
        0:       begin ga = {7'd0, q_rdy}; gb = q_wait; end
        1:       begin ga = {6'd0, avail}; gb = cur.b; end
        default: begin ga = {3'd0, err, lqf, sqf, lqe, sqe}; gb = cur.b; end
      endcase
      if (ga !== cur.a || gb !== cur.b) begin
        miscompares++;
        $display("FAIL %s kind=%0d got a=%h b=%h exp a=%h b=%h",
                 cur.req, cur.kind, ga, gb, cur.a, cur.b);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    disp_v = 0; cmpl_v = 0;
  endtask

  task automatic disp(input logic [7:0] i, input logic l, input logic s, input logic sd);
    disp_v = 1; disp_idx = i; disp_ld = l; disp_st = s; disp_sd = sd;
    tick();
  endtask

  task automatic cmpl(input logic [7:0] i, input logic l, input logic s);
    cmpl_v = 1; cmpl_idx = i; cmpl_ld = l; cmpl_st = s;
    tick();
  endtask

  task automatic query(input logic [7:0] i, input logic l, input logic s,
                       input logic rdy, input logic [7:0] w, input string req);
    exp_t e;
    q_idx = i; q_ld = l; q_st = s;
    e.kind = 0; e.a = {7'd0, rdy}; e.b = w; e.req = req;
    sb.push_back(e);
    tick();
  endtask

  task automatic chk_avail(input logic l, input logic s, input logic [1:0] code, input string req);
    exp_t e;
    disp_ld = l; disp_st = s;
    e.kind = 1; e.a = {6'd0, code}; e.b = 8'd0; e.req = req;
    sb.push_back(e);
    tick();
  endtask

  task automatic chk_status(input logic e_err, input logic e_lqf, input logic e_sqf,
                            input logic e_lqe, input logic e_sqe, input string req);
    exp_t e;
    e.kind = 2; e.a = {3'd0, e_err, e_lqf, e_sqf, e_lqe, e_sqe}; e.b = 8'd0; e.req = req;
    sb.push_back(e);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk_status(0, 0, 0, 1, 1, "R12 reset");
    chk_avail(1, 1, 2'd0, "R3 empty available");

    // interleaved loads and stores
    disp(8'd10, 1, 0, 0);
    chk_status(0, 0, 0, 0, 1, "R1 load only");
    disp(8'd11, 0, 1, 0);
    disp(8'd12, 1, 0, 0);
    disp(8'd13, 0, 1, 0);
    chk_status(0, 0, 0, 0, 0, "R1 both tables");
    query(8'd10, 1, 0, 1, 8'd10, "R8 R9 oldest load");
    query(8'd12, 1, 0, 0, 8'd11, "R7 load after store");
    query(8'd11, 0, 1, 0, 8'd10, "R8 store after load");
    no_alias = 1;
    query(8'd12, 1, 0, 1, 8'd12, "R6 no-alias load");
    query(8'd13, 0, 1, 0, 8'd11, "R7 store in no-alias");
    no_alias = 0;
    cmpl(8'd10, 1, 0);
    query(8'd11, 0, 1, 1, 8'd11, "R10 R8 store freed");
    cmpl(8'd11, 0, 1);
    query(8'd12, 1, 0, 1, 8'd12, "R8 load older than store");
    query(8'd13, 0, 1, 0, 8'd12, "R8 store behind load");
    cmpl(8'd12, 1, 0);
    cmpl(8'd13, 0, 1);
    chk_status(0, 0, 0, 1, 1, "R10 drained");

    // load barrier
    disp(8'd20, 1, 0, 0);
    disp(8'd21, 1, 0, 1);
    disp(8'd22, 1, 0, 0);
    query(8'd22, 1, 0, 0, 8'd21, "R4 younger than barrier");
    query(8'd21, 1, 0, 0, 8'd20, "R4 barrier behind load");
    query(8'd20, 1, 0, 1, 8'd20, "R4 older load ready");
    cmpl(8'd20, 1, 0);
    query(8'd21, 1, 0, 1, 8'd21, "R4 barrier now oldest");
    cmpl(8'd21, 1, 0);
    query(8'd22, 1, 0, 1, 8'd22, "R10 barrier retired");
    cmpl(8'd22, 1, 0);

    // store barrier
    disp(8'd30, 0, 1, 0);
    disp(8'd31, 0, 1, 1);
    disp(8'd32, 0, 1, 0);
    query(8'd32, 0, 1, 0, 8'd31, "R5 younger than barrier");
    query(8'd31, 0, 1, 0, 8'd30, "R5 barrier behind store");
    cmpl(8'd30, 0, 1);
    query(8'd31, 0, 1, 1, 8'd31, "R5 barrier now oldest");
    cmpl(8'd31, 0, 1);
    cmpl(8'd32, 0, 1);

    // out-of-order barrier completion
    disp(8'd40, 1, 0, 1);
    disp(8'd41, 1, 0, 1);
    disp(8'd42, 1, 0, 0);
    cmpl(8'd41, 1, 0);
    cmpl(8'd40, 1, 0);
    query(8'd42, 1, 0, 0, 8'd41, "R10 non-oldest barrier kept");
    cmpl(8'd41, 1, 0);
    query(8'd42, 1, 0, 1, 8'd42, "R10 barrier retired as oldest");
    cmpl(8'd42, 1, 0);

    // load+store barrier lands in both sets
    disp(8'd70, 1, 1, 1);
    disp(8'd71, 0, 1, 0);
    disp(8'd72, 1, 0, 0);
    query(8'd71, 0, 1, 0, 8'd70, "R2 store barrier mark");
    query(8'd72, 1, 0, 0, 8'd70, "R2 load barrier mark");
    cmpl(8'd70, 1, 1);
    query(8'd72, 1, 0, 0, 8'd71, "R7 after barrier gone");
    cmpl(8'd71, 0, 1);
    cmpl(8'd72, 1, 0);
    chk_status(0, 0, 0, 1, 1, "R10 drained again");

    // duplicates, fullness, availability
    disp(8'd50, 1, 0, 0);
    disp(8'd50, 1, 0, 0);
    chk_status(1, 0, 0, 0, 1, "R11 duplicate flagged");
    disp(8'd51, 1, 0, 0);
    disp(8'd52, 1, 0, 0);
    chk_status(1, 0, 0, 0, 1, "R11 duplicate not stored");
    disp(8'd53, 1, 0, 0);
    chk_status(1, 1, 0, 0, 1, "R1 load table full");
    chk_avail(1, 0, 2'd1, "R3 load table full");
    chk_avail(0, 1, 2'd0, "R3 store room");
    for (int k = 0; k < 4; k++) disp(8'(60 + k), 0, 1, 0);
    chk_avail(1, 1, 2'd1, "R3 load priority");
    chk_avail(0, 1, 2'd2, "R3 store table full");
    disp(8'd54, 1, 0, 0);
    for (int k = 0; k < 4; k++) cmpl(8'(50 + k), 1, 0);
    chk_status(1, 0, 1, 1, 0, "R11 overflow not stored");
    chk_avail(1, 1, 2'd2, "R3 store full only");
    for (int k = 0; k < 4; k++) cmpl(8'(60 + k), 0, 1);
    chk_status(1, 0, 0, 1, 1, "R11 sticky");

    tick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule